// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it compares the source registers of the instruction in decode with the destinations of the instructions in execute and memory. From that comparison it picks where each decode operand comes from: the register file, the execute result, or the memory-stage result. It requests a one-cycle stall when a load in execute feeds the instruction in decode. Branches and jumps resolve in execute. When one of them was mispredicted, the block flushes fetch and decode and supplies the corrected instruction index.

Program counters are instruction indices, not byte addresses. The sequential successor of index `p` is `p+1`, and a direct branch target is `p` plus a signed offset counted in instructions. Because the pipeline evaluates its stages from writeback back to fetch, execute and memory results are already present in the same cycle that decode reads them. All decisions are therefore combinational.

The block owns one piece of state: whether the execute and memory slots hold real instructions. It derives this from the bubbles it injects itself and from the decode valid flag, so a squashed or empty slot never forwards a result, stalls decode or redirects fetch.

Top module: `hazard_ctl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release, the execute and memory slots count as empty. Both forward selects are 0, and `hold_fd` and `redirect` are 0, whatever the other inputs are.
- R2: Suppose a decode source is in use, is nonzero, and equals `ex_rd` of a valid execute slot with `ex_wen`=1. Its select is then 1 and its operand equals `ex_alu`. Select encoding: 0 = register file, 1 = execute result, 2 = memory result, and 3 never appears.
- R3: Suppose a decode source in use, nonzero, matches `mem_rd` of a valid memory slot with `mem_wen`=1 and has no execute match. Its select is then 2 and its operand equals `mem_data`. With no match at all, the select is 0 and the operand equals the register-file value.
- R4: When the execute and memory slots both match the same source, the execute result (select 1) is chosen.
- R5: Source register 0 is never forwarded and never causes a stall.
- R6: A source whose use flag is 0 gets select 0 and causes no stall.
- R7: A load in a valid execute slot whose `ex_rd` matches a used, nonzero decode source, while `id_valid`=1, raises `hold_fd` and `bubble_ex` for exactly one cycle. On the following cycle the execute slot is empty, so the same value comes from the memory slot (select 2).
- R8: A valid branch or jump in execute is mispredicted when its actual next index differs from the predicted next index. In that case `flush_if`, `flush_id`, `bubble_ex` and `redirect` are all 1. A correct prediction raises none of them, and `redirect` is never 1 in two consecutive cycles.
- R9: The actual next index is `ex_pc+1` when not taken. When taken it is `ex_reg_tgt` if `ex_jreg`=1, and otherwise `ex_pc+ex_off`, with the offset in two's complement and the sum wrapping at `PW` bits. The predicted next index is `ex_pred_tgt` if `ex_pred_taken`=1, and `ex_pc+1` otherwise. `redirect_pc` carries the actual next index.
- R10: When a misprediction and a load-use hazard occur in the same cycle, the flush wins: `hold_fd` is 0, and `bubble_ex` and both flushes are 1.
- R11: A cycle with `bubble_ex`=1 or `id_valid`=0 leaves the execute slot empty for the next cycle. That slot then cannot forward (select 1), stall or redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode holds a real instruction |
| id_rs1 | input | RW | First decode source register |
| id_rs2 | input | RW | Second decode source register |
| id_use1 | input | 1 | First source is read |
| id_use2 | input | 1 | Second source is read |
| rf_rs1 | input | DW | Register-file value of first source |
| rf_rs2 | input | DW | Register-file value of second source |
| ex_rd | input | RW | Execute-stage destination |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_alu | input | DW | Execute-stage result |
| mem_rd | input | RW | Memory-stage destination |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_data | input | DW | Memory-stage result (load data for loads) |
| ex_ctrl | input | 1 | Execute holds a branch or jump |
| ex_jreg | input | 1 | The jump target comes from a register |
| ex_taken | input | 1 | Actual branch outcome |
| ex_pc | input | PW | Instruction index of the execute-stage instruction |
| ex_off | input | PW | Signed branch offset in instructions |
| ex_reg_tgt | input | PW | Register-computed jump target index |
| ex_pred_taken | input | 1 | Predicted outcome |
| ex_pred_tgt | input | PW | Predicted target index |
| fwd_a | output | 2 | Select for the first operand |
| fwd_b | output | 2 | Select for the second operand |
| opnd_a | output | DW | Forwarded first operand |
| opnd_b | output | DW | Forwarded second operand |
| hold_fd | output | 1 | Hold the fetch and decode registers |
| bubble_ex | output | 1 | Load a no-op into execute |
| flush_if | output | 1 | Squash the fetch-stage instruction |
| flush_id | output | 1 | Squash the decode-stage instruction |
| redirect | output | 1 | Load `redirect_pc` into fetch |
| redirect_pc | output | PW | Correct next instruction index |

## Verification
The assertions check several rules on every cycle. Register 0 never gets a forward select. Select 3 never appears. A stall always comes with a bubble and never lasts two cycles. A redirect always flushes both front stages and suppresses the stall. After any bubble, the execute slot neither forwards nor stalls. The values carried are left to the bench's scenarios: operand values, execute-over-memory priority, the wrapped branch arithmetic for negative offsets and register jumps, and the hand-off from a stalled load to memory forwarding. The bench covers these with directed cases and a randomized instruction stream checked against a model built from the requirements.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int RW = 5,
  parameter int DW = 32,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_valid,
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic          id_use1,
  input  logic          id_use2,
  input  logic [DW-1:0] rf_rs1,
  input  logic [DW-1:0] rf_rs2,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [DW-1:0] ex_alu,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [DW-1:0] mem_data,
  input  logic          ex_ctrl,
  input  logic          ex_jreg,
  input  logic          ex_taken,
  input  logic [PW-1:0] ex_pc,
  input  logic [PW-1:0] ex_off,
  input  logic [PW-1:0] ex_reg_tgt,
  input  logic          ex_pred_taken,
  input  logic [PW-1:0] ex_pred_tgt,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b,
  output logic          hold_fd,
  output logic          bubble_ex,
  output logic          flush_if,
  output logic          flush_id,
  output logic          redirect,
  output logic [PW-1:0] redirect_pc
);
  localparam logic [1:0]    SRC_RF  = 2'd0;
  localparam logic [1:0]    SRC_EX  = 2'd1;
  localparam logic [1:0]    SRC_MEM = 2'd2;
  localparam logic [PW-1:0] STEP    = PW'(1);

  logic ex_vld, mem_vld;
  logic ex_src, mem_src;
  logic a_ex, a_mem, b_ex, b_mem;
  logic load_use, mispred;
  logic [PW-1:0] seq_pc, taken_pc, act_pc, pred_pc;

  assign ex_src  = ex_vld & ex_wen;
  assign mem_src = mem_vld & mem_wen;

  assign a_ex  = id_use1 && (id_rs1 != '0) && ex_src  && (ex_rd  == id_rs1);
  assign a_mem = id_use1 && (id_rs1 != '0) && mem_src && (mem_rd == id_rs1);
  assign b_ex  = id_use2 && (id_rs2 != '0) && ex_src  && (ex_rd  == id_rs2);
  assign b_mem = id_use2 && (id_rs2 != '0) && mem_src && (mem_rd == id_rs2);

  assign fwd_a = a_ex ? SRC_EX : (a_mem ? SRC_MEM : SRC_RF);
  assign fwd_b = b_ex ? SRC_EX : (b_mem ? SRC_MEM : SRC_RF);

  always_comb begin
    case (fwd_a)
      SRC_EX:  opnd_a = ex_alu;
      SRC_MEM: opnd_a = mem_data;
      default: opnd_a = rf_rs1;
    endcase
    case (fwd_b)
      SRC_EX:  opnd_b = ex_alu;
      SRC_MEM: opnd_b = mem_data;
      default: opnd_b = rf_rs2;
    endcase
  end

  assign seq_pc   = ex_pc + STEP;
  assign taken_pc = ex_jreg ? ex_reg_tgt : (ex_pc + ex_off);
  assign act_pc   = ex_taken ? taken_pc : seq_pc;
  assign pred_pc  = ex_pred_taken ? ex_pred_tgt : seq_pc;
  assign mispred  = ex_vld & ex_ctrl & (act_pc != pred_pc);

  assign load_use = id_valid & ex_load & (a_ex | b_ex) & ~mispred;

  assign hold_fd     = load_use;
  assign bubble_ex   = load_use | mispred;
  assign flush_if    = mispred;
  assign flush_id    = mispred;
  assign redirect    = mispred;
  assign redirect_pc = act_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_vld  <= 1'b0;
      mem_vld <= 1'b0;
    end else begin
      ex_vld  <= id_valid & ~bubble_ex;
      mem_vld <= ex_vld;
    end
  end
endmodule

module hazard_ctl_chk #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [RW-1:0] id_rs1,
  input logic [RW-1:0] id_rs2,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          hold_fd,
  input logic          bubble_ex,
  input logic          flush_if,
  input logic          flush_id,
  input logic          redirect
);
  assert_x0_never_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((id_rs1 == '0) |-> (fwd_a == 2'd0)) and ((id_rs2 == '0) |-> (fwd_b == 2'd0)));

  assert_sel_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'd3) && (fwd_b != 2'd3));

  assert_stall_bubbles_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_fd |-> bubble_ex);

  assert_stall_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_fd |=> !hold_fd);

  assert_flush_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (!hold_fd && flush_if && flush_id && bubble_ex));

  assert_no_double_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);

  assert_bubble_empties_ex_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_ex |=> (fwd_a != 2'd1 && fwd_b != 2'd1 && !hold_fd));
endmodule

bind hazard_ctl hazard_ctl_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .hold_fd(hold_fd), .bubble_ex(bubble_ex),
  .flush_if(flush_if), .flush_id(flush_id), .redirect(redirect)
);

// File: tb/sim_hazard_ctl.sv
module sim_hazard_ctl;
  localparam int RW = 5;
  localparam int DW = 32;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          id_valid, id_use1, id_use2;
  logic [RW-1:0] id_rs1, id_rs2, ex_rd, mem_rd;
  logic [DW-1:0] rf_rs1, rf_rs2, ex_alu, mem_data;
  logic          ex_wen, ex_load, mem_wen;
  logic          ex_ctrl, ex_jreg, ex_taken, ex_pred_taken;
  logic [PW-1:0] ex_pc, ex_off, ex_reg_tgt, ex_pred_tgt;
  logic [1:0]    fwd_a, fwd_b;
  logic [DW-1:0] opnd_a, opnd_b;
  logic          hold_fd, bubble_ex, flush_if, flush_id, redirect;
  logic [PW-1:0] redirect_pc;

  hazard_ctl #(.RW(RW), .DW(DW), .PW(PW)) u0 (.*);

  typedef struct {
    string         tag;
    logic [1:0]    fa, fb;
    logic [DW-1:0] oa, ob;
    logic          hold, bub, fl, red;
    logic [PW-1:0] rpc;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int fails = 0;
  logic ex_m = 1'b0;
  logic mem_m = 1'b0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] msel(input logic [RW-1:0] rs, input logic use_it);
    if (!use_it || rs == '0) return 2'd0;
    if (ex_m && ex_wen && ex_rd == rs) return 2'd1;
    if (mem_m && mem_wen && mem_rd == rs) return 2'd2;
    return 2'd0;
  endfunction

  task automatic clr();
    id_valid = 1; id_use1 = 0; id_use2 = 0; id_rs1 = 0; id_rs2 = 0;
    rf_rs1 = 32'h1111_0001; rf_rs2 = 32'h2222_0002;
    ex_rd = 0; ex_wen = 0; ex_load = 0; ex_alu = 32'hEEEE_0003;
    mem_rd = 0; mem_wen = 0; mem_data = 32'hDDDD_0004;
    ex_ctrl = 0; ex_jreg = 0; ex_taken = 0; ex_pred_taken = 0;
    ex_pc = 0; ex_off = 0; ex_reg_tgt = 0; ex_pred_tgt = 0;
  endtask

  task automatic go(input string tag);
    exp_t e;
    logic [PW-1:0] tgt, act, pred;
    logic mis, lu;
    e.tag = tag;
    e.fa = msel(id_rs1, id_use1);
    e.fb = msel(id_rs2, id_use2);
    e.oa = (e.fa == 2'd1) ? ex_alu : (e.fa == 2'd2) ? mem_data : rf_rs1;
    e.ob = (e.fb == 2'd1) ? ex_alu : (e.fb == 2'd2) ? mem_data : rf_rs2;
    tgt  = ex_jreg ? ex_reg_tgt : PW'(ex_pc + ex_off);
    act  = ex_taken ? tgt : PW'(ex_pc + 1);
    pred = ex_pred_taken ? ex_pred_tgt : PW'(ex_pc + 1);
    mis  = ex_m && ex_ctrl && (act != pred);
    lu   = id_valid && ex_load && (e.fa == 2'd1 || e.fb == 2'd1) && !mis;
    e.hold = lu; e.bub = lu | mis; e.fl = mis; e.red = mis; e.rpc = act;
    q.push_back(e);
    @(negedge clk);
    mem_m = rst_n ? ex_m : 1'b0;
    ex_m  = rst_n ? (id_valid && !e.bub) : 1'b0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #4;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.tag, "fwd_a", 64'(fwd_a), 64'(e.fa));
        chk(e.tag, "fwd_b", 64'(fwd_b), 64'(e.fb));
        chk(e.tag, "opnd_a", 64'(opnd_a), 64'(e.oa));
        chk(e.tag, "opnd_b", 64'(opnd_b), 64'(e.ob));
        chk(e.tag, "hold_fd", 64'(hold_fd), 64'(e.hold));
        chk(e.tag, "bubble_ex", 64'(bubble_ex), 64'(e.bub));
        chk(e.tag, "flush_if", 64'(flush_if), 64'(e.fl));
        chk(e.tag, "flush_id", 64'(flush_id), 64'(e.fl));
        chk(e.tag, "redirect", 64'(redirect), 64'(e.red));
        if (e.red) chk(e.tag, "redirect_pc", 64'(redirect_pc), 64'(e.rpc));
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : driver
    clr();
    @(negedge clk);
    // R1: reset keeps slots empty even with matching inputs
    id_use1 = 1; id_rs1 = 5; ex_rd = 5; ex_wen = 1; ex_load = 1;
    mem_rd = 5; mem_wen = 1; ex_ctrl = 1; ex_taken = 1; ex_off = 4;
    go("R1 in reset");
    go("R1 in reset");
    rst_n = 1;
    go("R1 first cycle");
    clr(); go("warm"); go("warm");
    // R2
    ex_rd = 5; ex_wen = 1; id_rs1 = 5; id_use1 = 1; go("R2 ex fwd");
    // R3
    clr(); mem_rd = 6; mem_wen = 1; id_rs2 = 6; id_use2 = 1; go("R3 mem fwd");
    clr(); id_rs1 = 3; id_use1 = 1; ex_rd = 4; ex_wen = 1; go("R3 no match");
    // R4
    clr(); ex_rd = 7; ex_wen = 1; mem_rd = 7; mem_wen = 1;
    id_rs1 = 7; id_use1 = 1; id_rs2 = 7; id_use2 = 1; go("R4 priority");
    // R5
    clr(); ex_rd = 0; ex_wen = 1; ex_load = 1; mem_rd = 0; mem_wen = 1;
    id_use1 = 1; id_use2 = 1; go("R5 x0");
    // R6
    clr(); ex_rd = 8; ex_wen = 1; ex_load = 1; id_rs2 = 8; id_use2 = 0; go("R6 unused");
    // R7: load-use, then memory forward
    clr(); ex_rd = 9; ex_wen = 1; ex_load = 1; id_rs1 = 9; id_use1 = 1; go("R7 stall");
    mem_rd = 9; mem_wen = 1; go("R7 after stall");
    clr(); go("warm");
    // R8
    ex_ctrl = 1; ex_pc = 10; ex_off = 5; ex_taken = 1;
    ex_pred_taken = 1; ex_pred_tgt = 15; go("R8 correct");
    ex_pred_taken = 0; go("R8 mispredict");
    go("R8 next cycle");
    // R9
    clr(); go("warm");
    ex_ctrl = 1; ex_pc = 10; ex_off = 16'hFFFD; ex_taken = 1; go("R9 negative offset");
    clr(); go("warm");
    ex_ctrl = 1; ex_jreg = 1; ex_reg_tgt = 100; ex_taken = 1; ex_pc = 40; go("R9 register jump");
    clr(); go("warm");
    ex_ctrl = 1; ex_pc = 16'hFFFF; ex_pred_taken = 1; ex_pred_tgt = 20; go("R9 not taken wrap");
    // R10
    clr(); go("warm");
    ex_ctrl = 1; ex_taken = 1; ex_off = 2; ex_pc = 3;
    ex_rd = 2; ex_wen = 1; ex_load = 1; id_rs1 = 2; id_use1 = 1; go("R10 flush wins");
    // R11
    clr(); go("warm"); id_valid = 0; go("R11 invalid id");
    id_valid = 1; ex_rd = 4; ex_wen = 1; ex_load = 1; id_rs1 = 4; id_use1 = 1; go("R11 empty ex");
    // randomized stream
    clr(); go("warm");
    for (int i = 0; i < 600; i++) begin
      id_valid = ($urandom_range(0, 9) != 0);
      id_rs1 = RW'($urandom_range(0, 3)); id_rs2 = RW'($urandom_range(0, 3));
      id_use1 = 1'($urandom); id_use2 = 1'($urandom);
      rf_rs1 = $urandom; rf_rs2 = $urandom; ex_alu = $urandom; mem_data = $urandom;
      ex_rd = RW'($urandom_range(0, 3)); ex_wen = 1'($urandom);
      ex_load = ($urandom_range(0, 2) == 0);
      mem_rd = RW'($urandom_range(0, 3)); mem_wen = 1'($urandom);
      ex_ctrl = ($urandom_range(0, 3) == 0); ex_jreg = 1'($urandom);
      ex_taken = 1'($urandom); ex_pred_taken = 1'($urandom);
      ex_pc = PW'($urandom); ex_off = PW'($urandom_range(0, 15) - 8);
      ex_reg_tgt = PW'($urandom); ex_pred_tgt = ($urandom_range(0, 1) == 0) ? PW'(ex_pc + ex_off) : PW'($urandom);
      go("random");
    end
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule